// File: doc/BRIEF.md
# External Clock Edge Conditioner

This block prepares an asynchronous external clock pin so that a timer running on a faster internal clock can count it. The pin is first brought into the internal clock domain by a two-stage synchronizer. A stability filter then accepts a new pin level only after it has held for a programmable number of internal clock cycles. An edge detector turns each accepted transition of the filtered level into a count-enable pulse, one internal cycle wide. A polarity code selects whether rising edges, falling edges or both produce pulses.

The filter code and polarity code are static inputs. They are expected to change only while the surrounding timer is idle. One polarity code value is reserved. While it is applied, the block raises a configuration-error flag and suppresses every pulse. When both edges are counted, the internal clock must run at least four times faster than the external clock.

Top module: `extclk_cond`

## Requirements
- R1: With polarity code 0, a count pulse is issued for each accepted low-to-high transition of the filtered level, and none for high-to-low transitions.
- R2: With polarity code 1, a count pulse is issued for each accepted high-to-low transition, and none for low-to-high transitions.
- R3: With polarity code 2, a count pulse is issued for every accepted transition in either direction.
- R4: With polarity code 3, `cfg_err` is 1 and no count pulse is issued. For the other codes `cfg_err` is 0, and it follows the code with no clock delay.
- R5: Filter code 0 accepts every change of the synchronized level. The pin passes two synchronizer flops. For a pin change made between rising edges, the pulse is high during the cycle that follows the (2 + N)-th rising edge after the change, where N = 2^code is the stability length.
- R6: Filter codes 1, 2 and 3 accept a new level only when the synchronized input has shown it for N = 2, 4 or 8 consecutive cycles. A pin change held for N cycles is accepted. One held for N-1 cycles is rejected.
- R7: A change that reverts before its stability count completes produces no pulse. A later change back to the new level starts the count again from zero.
- R8: Each accepted edge gives exactly one pulse, one internal cycle wide.
- R9: After reset the filtered level takes the synchronized pin level. No pulse results, whatever the pin level is when reset is released, and no pulse is issued during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_pin | input | 1 | Raw asynchronous external clock |
| flt_code | input | 2 | Stability filter code, length 2^code cycles |
| pol_code | input | 2 | Active edge: 0 rising, 1 falling, 2 both, 3 reserved |
| cnt_pulse | output | 1 | One-cycle count-enable pulse |
| cfg_err | output | 1 | Reserved polarity code applied |

## Verification
On every cycle, assertions check four things. Each pulse matches the direction of the filtered level for the selected polarity. No pulse appears while the reserved code is applied. Pulses are single-cycle unless both edges are counted. A level accepted under a non-zero filter code was shown by the synchronizer on at least the two preceding cycles. The bench scenarios show the rest: the exact pulse latency for each filter length, the N versus N-1 hold boundary, glitches that restart the count, and the absence of a pulse after reset with the pin held high.

// File: rtl/extclk_cond_pkg.sv
package extclk_cond_pkg;

  typedef enum logic [1:0] {
    POL_RISE = 2'd0,
    POL_FALL = 2'd1,
    POL_BOTH = 2'd2,
    POL_BAD  = 2'd3
  } pol_e;

  // stability length in internal cycles for a filter code
  function automatic int unsigned stable_len(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // width of a counter that must reach stable_len(max code) - 1
  function automatic int unsigned len_cnt_w(input int unsigned code_w);
    int unsigned mx;
    mx = stable_len((32'd1 << code_w) - 1);
    return (mx <= 2) ? 1 : $clog2(mx);
  endfunction

endpackage

// File: rtl/extclk_sync.sv
module extclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/extclk_filter.sv
module extclk_filter
  import extclk_cond_pkg::*;
#(
  parameter int CODE_W = 2,
  parameter int WARM   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [CODE_W-1:0] code,
  output logic              lvl,
  output logic              primed,
  output logic              accept
);
  localparam int CNT_W = len_cnt_w(CODE_W);
  localparam int WU_W  = $clog2(WARM + 1);

  logic [CNT_W-1:0] cnt;
  logic [WU_W-1:0]  wu;
  logic [CNT_W-1:0] need_m1;
  logic             differs;

  assign need_m1 = CNT_W'(stable_len(32'(code)) - 1);
  assign primed  = (wu == WU_W'(WARM));
  assign differs = (sync_in != lvl);
  assign accept  = primed && differs && (cnt == need_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wu  <= '0;
      lvl <= 1'b0;
      cnt <= '0;
    end else if (!primed) begin
      // track the synchronizer while it fills, so no edge is seen later
      wu  <= wu + 1'b1;
      lvl <= sync_in;
      cnt <= '0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (accept) begin
      lvl <= sync_in;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: with any non-zero code a new level must have been seen twice in a row
  assert_stable_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(primed) && code != '0 && lvl != $past(lvl))
      |-> ($past(sync_in) == lvl && $past(sync_in, 2) == lvl));
endmodule

// File: rtl/extclk_edge.sv
module extclk_edge
  import extclk_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic       primed,
  input  logic [1:0] pol,
  output logic       pulse,
  output logic       cfg_err
);
  logic lvl_d;
  logic armed;
  logic rise_ev;
  logic fall_ev;
  logic sel_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      armed <= 1'b0;
    end else begin
      lvl_d <= lvl;
      armed <= primed;
    end
  end

  assign rise_ev = lvl & ~lvl_d;
  assign fall_ev = ~lvl & lvl_d;

  always_comb begin
    case (pol_e'(pol))
      POL_RISE: sel_ev = rise_ev;
      POL_FALL: sel_ev = fall_ev;
      POL_BOTH: sel_ev = rise_ev | fall_ev;
      default:  sel_ev = 1'b0;
    endcase
  end

  assign cfg_err = (pol == POL_BAD);
  assign pulse   = armed & sel_ev & ~cfg_err;

  assert_no_pulse_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> pol != POL_BAD);
  assert_rise_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && pol == POL_RISE) |-> (lvl && !lvl_d));
  assert_fall_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && pol == POL_FALL) |-> (!lvl && lvl_d));
  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && pol != POL_BOTH) |=> !pulse);
endmodule

// File: rtl/extclk_cond.sv
module extclk_cond
  import extclk_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_pin,
  input  logic [CODE_W-1:0] flt_code,
  input  logic [1:0]        pol_code,
  output logic              cnt_pulse,
  output logic              cfg_err
);
  localparam int WARM = SYNC_STAGES + 1;

  logic pin_sync;
  logic flt_lvl;
  logic flt_primed;
  logic flt_accept;

  extclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_clk_pin),
    .dout (pin_sync)
  );

  extclk_filter #(.CODE_W(CODE_W), .WARM(WARM)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_in(pin_sync),
    .code   (flt_code),
    .lvl    (flt_lvl),
    .primed (flt_primed),
    .accept (flt_accept)
  );

  extclk_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (flt_lvl),
    .primed (flt_primed),
    .pol    (pol_code),
    .pulse  (cnt_pulse),
    .cfg_err(cfg_err)
  );

  // R8: an accepted change is followed by exactly one pulse for both-edge counting
  assert_accept_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_accept && $past(flt_primed) && pol_code == 2'd2) |=> cnt_pulse);
endmodule

// File: tb/extclk_cond_tb.sv
module extclk_cond_tb;
  localparam int CLK_HALF = 5;
  localparam int SYNC_LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_pin = 1'b1;
  logic [1:0] flt_code = 2'd0;
  logic [1:0] pol_code = 2'd0;
  logic       cnt_pulse;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int npulse = 0;
  logic lvl_m = 1'b1;
  bit done = 0;

  int    exp_t[$];
  string exp_r[$];

  extclk_cond u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_clk_pin(ext_clk_pin),
    .flt_code   (flt_code),
    .pol_code   (pol_code),
    .cnt_pulse  (cnt_pulse),
    .cfg_err    (cfg_err)
  );

  always #CLK_HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare pulses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_t.size() > 0 && exp_t[0] == cyc) begin
        checks++;
        if (!cnt_pulse) begin
          errors++;
          $display("FAIL %s: pulse at cycle %0d actual 0 expected 1", exp_r[0], cyc);
        end
        void'(exp_t.pop_front());
        void'(exp_r.pop_front());
      end else if (cnt_pulse) begin
        checks++;
        errors++;
        $display("FAIL R8: unexpected pulse at cycle %0d actual 1 expected 0", cyc);
      end
      if (cnt_pulse) npulse++;
    end
  end

  task automatic check(input string rid, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rid, act, exp);
    end
  endtask

  // driver: set the pin and hold it, pushing the pulse it must cause
  task automatic drive(input logic v, input int hold, input string rid);
    int  need;
    bit  edge_ok;
    @(negedge clk);
    need = 1 << flt_code;
    ext_clk_pin = v;
    if (v != lvl_m && hold >= need) begin
      lvl_m = v;
      edge_ok = (pol_code == 2'd0 && v) || (pol_code == 2'd1 && !v) || (pol_code == 2'd2);
      if (edge_ok) begin
        exp_t.push_back(cyc + SYNC_LAT + need);
        exp_r.push_back(rid);
      end
    end
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic phase_count(input string rid, input int base, input int exp);
    check(rid, npulse - base, exp);
  endtask

  initial begin
    int base;
    // R9: reset with the pin high
    repeat (4) @(negedge clk);
    check("R9", cnt_pulse, 0);
    check("R4", cfg_err, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R9", npulse, 0);

    // R1 + R5: rising edges, filter code 0
    base = npulse;
    drive(1'b0, 14, "R1");
    drive(1'b1, 14, "R5");
    drive(1'b0, 14, "R1");
    drive(1'b1, 14, "R1");
    phase_count("R1", base, 2);

    // R2: falling edges, filter code 1
    pol_code = 2'd1; flt_code = 2'd1;
    base = npulse;
    drive(1'b0, 14, "R2");
    drive(1'b1, 14, "R2");
    drive(1'b0, 14, "R2");
    phase_count("R2", base, 2);

    // R3: both edges, filter code 2
    pol_code = 2'd2; flt_code = 2'd2;
    base = npulse;
    drive(1'b1, 14, "R3");
    drive(1'b0, 14, "R3");
    drive(1'b1, 14, "R3");
    phase_count("R3", base, 3);

    // R6: code 3 boundary, hold 7 rejected, hold 8 accepted
    flt_code = 2'd3;
    base = npulse;
    drive(1'b0, 7, "R6");
    drive(1'b1, 20, "R6");
    phase_count("R6", base, 0);
    drive(1'b0, 8, "R6");
    drive(1'b0, 16, "R6");
    phase_count("R6", base, 1);

    // R6: code 1 boundary, one-cycle glitch rejected
    flt_code = 2'd1;
    base = npulse;
    drive(1'b1, 1, "R6");
    drive(1'b0, 14, "R6");
    phase_count("R6", base, 0);

    // R7: code 2, interrupted change restarts the count
    flt_code = 2'd2;
    base = npulse;
    drive(1'b1, 3, "R7");
    drive(1'b0, 1, "R7");
    drive(1'b1, 3, "R7");
    drive(1'b0, 14, "R7");
    phase_count("R7", base, 0);
    drive(1'b1, 14, "R7");
    phase_count("R7", base, 1);

    // R4: reserved polarity
    pol_code = 2'd3; flt_code = 2'd0;
    #1;
    check("R4", cfg_err, 1);
    base = npulse;
    lvl_m = 1'b1;
    begin
      // expectation-free toggles: the model level tracks the pin
      @(negedge clk); ext_clk_pin = 1'b0; repeat (9) @(negedge clk);
      ext_clk_pin = 1'b1; repeat (10) @(negedge clk);
    end
    phase_count("R4", base, 0);
    pol_code = 2'd0;
    #1;
    check("R4", cfg_err, 0);
    drive(1'b0, 14, "R1");
    drive(1'b1, 14, "R1");

    // R9: reset again with pin high, then release
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base = npulse;
    repeat (12) @(negedge clk);
    phase_count("R9", base, 0);

    check("R8", exp_t.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule